// File: doc/BRIEF.md
# Operand Segment Register Resolver

This block decides which segment register a memory operand of an instruction uses. The register can be code, stack, data, extra, F or G, or the answer can be that no segment applies. A front end that has already split out the prefix bytes presents them together with the first opcode byte, the opcode length, the address size, a long-mode flag and a code for the operand's base register. It raises a valid strobe for that transaction.

One clock later the block returns a 3-bit segment index, an error flag and a debug bit. The debug bit marks base-register codes that the resolver does not know. The result takes account of:
- segment override prefixes, up to four slots;
- the default segment tied to the base register;
- string instructions, whose destination index register never accepts an override;
- long mode, which keeps only the F and G overrides.

Top module: `segsel_resolver`

## Requirements
- R1: A result (`res_valid` high for exactly one cycle) appears on the clock edge that samples `req_valid` high; `res_valid` is low after any edge that samples `req_valid` low. Index encoding: 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS, 6=IGNORE, 7=NONE (reported only with `res_err`).
- R2: An instruction counts as a string instruction only when `opc_len` is 1 and `opc_byte` is in 0x6C..0x6F, 0xA4..0xA7 or 0xAA..0xAF.
- R3: Prefix slot k occupies `pfx_bytes[8k+7:8k]`, and only slots below `pfx_count` are examined. An override byte selects a segment: 0x26 selects ES, 0x2E CS, 0x36 SS, 0x3E DS, 0x64 FS and 0x65 GS. A single override replaces the default segment.
- R4: More than one override byte among the examined slots sets `res_err` with index 7, unless R5 or R6 applies.
- R5: Base code 16 (instruction pointer) yields CS outside long mode and IGNORE in long mode, never an error, whatever the prefixes are.
- R6: Base code 7 (rDI) in a string instruction ignores all prefixes and yields ES, or IGNORE in long mode, never an error.
- R7: With no override and outside long mode, the defaults are:
  - DS for code 3 (rBX), code 6 (rSI) and code 17 (no base register, displacement only);
  - SS for code 4 (rSP) and code 5 (rBP);
  - DS for code 7 (rDI) in a non-string instruction.
- R8: `addr_size` encodes 0=16-bit, 1=32-bit and 2=64-bit. When no override is used, base codes 0, 1 and 2 (rAX, rCX, rDX) raise `res_err` with 16-bit addressing and yield DS otherwise.
- R9: In long mode a default yields IGNORE, never an error. FS and GS overrides pass through, and any other single override yields IGNORE.
- R10: The other base codes follow the default rules of code 3: codes 8..15 outside long mode, and codes 18..31 in any mode. For these codes `res_odd` is 1; for every other code it is 0.
- R11: After reset `res_valid`=0, `res_seg`=6, `res_err`=0 and `res_odd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| pfx_bytes | input | 32 | Prefix slots, slot 0 in bits 7:0 |
| pfx_count | input | 3 | Number of valid prefix slots (0..4) |
| opc_byte | input | 8 | First opcode byte |
| opc_len | input | 2 | Opcode length in bytes |
| addr_size | input | 2 | 0=16, 1=32, 2=64-bit addressing |
| long_mode | input | 1 | 64-bit mode flag |
| base_reg | input | 5 | Operand base-register code |
| res_valid | output | 1 | Result strobe |
| res_seg | output | 3 | Segment index |
| res_err | output | 1 | Fault flag |
| res_odd | output | 1 | Unrecognised base-register code |

## Verification
The bench probes the edges of the string-opcode ranges (0xA3, 0xA8, 0x6B) and a string opcode whose length is two bytes. A comparator off by one, or one that ignores the length, would return ES instead of DS for the destination index register. It sends double overrides alongside the instruction pointer and alongside the string destination register. A design that counts overrides before it handles these exemptions would flag a false error. It also checks an accumulator base under 16-bit addressing with one override and in long mode. A resolver that judged the register's legality before the override or the mode would raise an error where none belongs. Override bytes in slots beyond `pfx_count` must leave the default untouched.

// File: rtl/segsel_pkg.sv
package segsel_pkg;
  typedef enum logic [2:0] {
    SEG_ES   = 3'd0,
    SEG_CS   = 3'd1,
    SEG_SS   = 3'd2,
    SEG_DS   = 3'd3,
    SEG_FS   = 3'd4,
    SEG_GS   = 3'd5,
    SEG_IGN  = 3'd6,
    SEG_NONE = 3'd7
  } seg_t;

  localparam logic [4:0] RC_AX  = 5'd0;
  localparam logic [4:0] RC_CX  = 5'd1;
  localparam logic [4:0] RC_DX  = 5'd2;
  localparam logic [4:0] RC_BX  = 5'd3;
  localparam logic [4:0] RC_SP  = 5'd4;
  localparam logic [4:0] RC_BP  = 5'd5;
  localparam logic [4:0] RC_SI  = 5'd6;
  localparam logic [4:0] RC_DI  = 5'd7;
  localparam logic [4:0] RC_IP  = 5'd16;
  localparam logic [4:0] RC_NOB = 5'd17;

  // Map one prefix byte to a segment, SEG_NONE when it is not an override.
  function automatic seg_t pfx_seg(input logic [7:0] b);
    case (b)
      8'h26:   pfx_seg = SEG_ES;
      8'h2E:   pfx_seg = SEG_CS;
      8'h36:   pfx_seg = SEG_SS;
      8'h3E:   pfx_seg = SEG_DS;
      8'h64:   pfx_seg = SEG_FS;
      8'h65:   pfx_seg = SEG_GS;
      default: pfx_seg = SEG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/segsel_strdet.sv
module segsel_strdet #(
  parameter int OPC_W = 8,
  parameter int LEN_W = 2
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [LEN_W-1:0] len,
  output logic             is_str
);
  logic in_io, in_mov, in_sto;
  always_comb begin
    in_io  = (opc >= OPC_W'('h6C)) && (opc <= OPC_W'('h6F));
    in_mov = (opc >= OPC_W'('hA4)) && (opc <= OPC_W'('hA7));
    in_sto = (opc >= OPC_W'('hAA)) && (opc <= OPC_W'('hAF));
    is_str = (len == LEN_W'(1)) && (in_io || in_mov || in_sto);
  end
endmodule

// File: rtl/segsel_ovscan.sv
module segsel_ovscan
  import segsel_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS*BYTE_W-1:0] pfx,
  input  logic [CNT_W-1:0]        cnt,
  output logic                    any_hit,
  output logic                    multi,
  output seg_t                    ov_seg
);
  logic [SLOTS-1:0] hit;
  seg_t             slot_seg [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_comb begin
      slot_seg[g] = pfx_seg(pfx[g*BYTE_W +: BYTE_W]);
      hit[g]      = (CNT_W'(g) < cnt) && (slot_seg[g] != SEG_NONE);
    end
  end

  always_comb begin
    ov_seg = SEG_NONE;
    for (int i = 0; i < SLOTS; i++)
      if (hit[i]) ov_seg = slot_seg[i];
    any_hit = |hit;
    multi   = $countones(hit) > 1;
  end
endmodule

// File: rtl/segsel_defmap.sv
module segsel_defmap
  import segsel_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] rc,
  input  logic             is_str,
  input  logic [1:0]       asz,
  input  logic             lmode,
  output seg_t             dseg,
  output logic             dbad,
  output logic             odd
);
  always_comb begin
    dbad = 1'b0;
    odd  = (rc > REG_W'(RC_NOB)) ||
           (!lmode && rc >= REG_W'(8) && rc < REG_W'(RC_IP));
    dseg = SEG_DS;
    if (lmode) begin
      dseg = SEG_IGN;
    end else begin
      case (rc)
        REG_W'(RC_AX), REG_W'(RC_CX), REG_W'(RC_DX): begin
          if (asz == 2'd0) begin
            dbad = 1'b1;
            dseg = SEG_NONE;
          end
        end
        REG_W'(RC_SP), REG_W'(RC_BP): dseg = SEG_SS;
        REG_W'(RC_DI):                dseg = is_str ? SEG_ES : SEG_DS;
        REG_W'(RC_IP):                dseg = SEG_CS;
        default:                      dseg = SEG_DS;
      endcase
    end
  end
endmodule

// File: rtl/segsel_resolver.sv
module segsel_resolver
  import segsel_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int BYTE_W = 8,
  parameter int REG_W  = 5,
  parameter int LEN_W  = 2,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [SLOTS*BYTE_W-1:0] pfx_bytes,
  input  logic [CNT_W-1:0]        pfx_count,
  input  logic [BYTE_W-1:0]       opc_byte,
  input  logic [LEN_W-1:0]        opc_len,
  input  logic [1:0]              addr_size,
  input  logic                    long_mode,
  input  logic [REG_W-1:0]        base_reg,
  output logic                    res_valid,
  output logic [2:0]              res_seg,
  output logic                    res_err,
  output logic                    res_odd
);
  logic is_str, any_hit, multi, dbad, odd;
  seg_t ov_seg, dseg, nxt_seg;
  logic nxt_err;

  segsel_strdet #(.OPC_W(BYTE_W), .LEN_W(LEN_W)) u_str (
    .opc(opc_byte), .len(opc_len), .is_str(is_str));

  segsel_ovscan #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_scan (
    .pfx(pfx_bytes), .cnt(pfx_count), .any_hit(any_hit),
    .multi(multi), .ov_seg(ov_seg));

  segsel_defmap #(.REG_W(REG_W)) u_def (
    .rc(base_reg), .is_str(is_str), .asz(addr_size), .lmode(long_mode),
    .dseg(dseg), .dbad(dbad), .odd(odd));

  always_comb begin
    nxt_err = 1'b0;
    if (base_reg == REG_W'(RC_IP)) begin
      nxt_seg = long_mode ? SEG_IGN : SEG_CS;
    end else if (base_reg == REG_W'(RC_DI) && is_str) begin
      nxt_seg = dseg;
    end else if (multi) begin
      nxt_err = 1'b1;
      nxt_seg = SEG_NONE;
    end else if (any_hit) begin
      if (long_mode && ov_seg != SEG_FS && ov_seg != SEG_GS) nxt_seg = SEG_IGN;
      else                                                  nxt_seg = ov_seg;
    end else begin
      nxt_seg = dseg;
      nxt_err = dbad;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_seg   <= SEG_IGN;
      res_err   <= 1'b0;
      res_odd   <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_seg <= nxt_seg;
        res_err <= nxt_err;
        res_odd <= odd;
      end
    end
  end

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);
  // R1
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);
  // R4
  err_means_none_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_err == (res_seg == 3'd7)));
  // R5
  ip_always_code_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && base_reg == REG_W'(RC_IP)) |=>
      (!res_err && res_seg == ($past(long_mode) ? 3'd6 : 3'd1)));
  // R9
  long_mode_set_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && long_mode) |=>
      (res_err || res_seg == 3'd6 || res_seg == 3'd4 || res_seg == 3'd5));
endmodule

// File: tb/segsel_resolver_test.sv
module segsel_resolver_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] pfx_bytes = '0;
  logic [2:0]  pfx_count = '0;
  logic [7:0]  opc_byte = '0;
  logic [1:0]  opc_len = 2'd1;
  logic [1:0]  addr_size = '0;
  logic        long_mode = 1'b0;
  logic [4:0]  base_reg = '0;
  logic        res_valid, res_err, res_odd;
  logic [2:0]  res_seg;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segsel_resolver uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .pfx_bytes(pfx_bytes),
    .pfx_count(pfx_count), .opc_byte(opc_byte), .opc_len(opc_len),
    .addr_size(addr_size), .long_mode(long_mode), .base_reg(base_reg),
    .res_valid(res_valid), .res_seg(res_seg), .res_err(res_err),
    .res_odd(res_odd));

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual={v,seg,err,odd}=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one request; sample after the capturing edge.
  task automatic op(input string tag, input logic [31:0] p, input logic [2:0] c,
                    input logic [7:0] o, input logic [1:0] l, input logic [1:0] a,
                    input logic lm, input logic [4:0] r,
                    input logic [2:0] es, input logic ee, input logic eo);
    @(negedge clk);
    req_valid = 1'b1; pfx_bytes = p; pfx_count = c; opc_byte = o;
    opc_len = l; addr_size = a; long_mode = lm; base_reg = r;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {res_valid, res_seg, res_err, res_odd}, {1'b1, es, ee, eo});
  endtask

  task automatic t_reset();
    chk("R11 reset", {res_valid, res_seg, res_err, res_odd}, {1'b0, 3'd6, 1'b0, 1'b0});
  endtask

  task automatic t_latency();
    op("R1 pulse", 32'h0, 3'd0, 8'h8B, 2'd1, 2'd1, 1'b0, 5'd3, 3'd3, 1'b0, 1'b0);
    @(negedge clk);
    chk("R1 drop", {res_valid, 5'd0}, 6'd0);
  endtask

  task automatic t_string();
    op("R2 A4", 0, 0, 8'hA4, 1, 1, 0, 5'd7, 3'd0, 0, 0);
    op("R2 AF", 0, 0, 8'hAF, 1, 1, 0, 5'd7, 3'd0, 0, 0);
    op("R2 6C", 0, 0, 8'h6C, 1, 1, 0, 5'd7, 3'd0, 0, 0);
    op("R2 A8", 0, 0, 8'hA8, 1, 1, 0, 5'd7, 3'd3, 0, 0);
    op("R2 A3", 0, 0, 8'hA3, 1, 1, 0, 5'd7, 3'd3, 0, 0);
    op("R2 6B", 0, 0, 8'h6B, 1, 1, 0, 5'd7, 3'd3, 0, 0);
    op("R2 len2", 0, 0, 8'h6C, 2, 1, 0, 5'd7, 3'd3, 0, 0);
  endtask

  task automatic t_override();
    op("R3 26", 32'h26, 1, 8'h8B, 1, 1, 0, 5'd3, 3'd0, 0, 0);
    op("R3 2E", 32'h2E, 1, 8'h8B, 1, 1, 0, 5'd3, 3'd1, 0, 0);
    op("R3 36", 32'h36, 1, 8'h8B, 1, 1, 0, 5'd3, 3'd2, 0, 0);
    op("R3 3E on SP", 32'h3E, 1, 8'h8B, 1, 1, 0, 5'd4, 3'd3, 0, 0);
    op("R3 64", 32'h64, 1, 8'h8B, 1, 1, 0, 5'd3, 3'd4, 0, 0);
    op("R3 65", 32'h65, 1, 8'h8B, 1, 1, 0, 5'd3, 3'd5, 0, 0);
    op("R3 slot2", 32'h0064_F066, 3, 8'h8B, 1, 1, 0, 5'd3, 3'd4, 0, 0);
    op("R3 beyond cnt", 32'h2E00_F066, 3, 8'h8B, 1, 1, 0, 5'd5, 3'd2, 0, 0);
  endtask

  task automatic t_multi();
    op("R4 two", 32'h652E, 2, 8'h8B, 1, 1, 0, 5'd3, 3'd7, 1, 0);
    op("R4 one counted", 32'h652E, 1, 8'h8B, 1, 1, 0, 5'd3, 3'd1, 0, 0);
  endtask

  task automatic t_ip();
    op("R5 ip legacy", 32'h6536, 2, 8'h8B, 1, 1, 0, 5'd16, 3'd1, 0, 0);
    op("R5 ip long", 32'h6536, 2, 8'h8B, 1, 2, 1, 5'd16, 3'd6, 0, 0);
  endtask

  task automatic t_di_string();
    op("R6 di str two ovr", 32'h362E, 2, 8'hAA, 1, 1, 0, 5'd7, 3'd0, 0, 0);
    op("R6 di str long", 32'h64, 1, 8'hAA, 1, 2, 1, 5'd7, 3'd6, 0, 0);
    op("R6 di nonstr ovr", 32'h64, 1, 8'h8B, 1, 1, 0, 5'd7, 3'd4, 0, 0);
  endtask

  task automatic t_defaults();
    op("R7 bx", 0, 0, 8'h8B, 1, 0, 0, 5'd3, 3'd3, 0, 0);
    op("R7 si", 0, 0, 8'h8B, 1, 0, 0, 5'd6, 3'd3, 0, 0);
    op("R7 nobase", 0, 0, 8'h8B, 1, 0, 0, 5'd17, 3'd3, 0, 0);
    op("R7 sp", 0, 0, 8'h8B, 1, 1, 0, 5'd4, 3'd2, 0, 0);
    op("R7 bp", 0, 0, 8'h8B, 1, 0, 0, 5'd5, 3'd2, 0, 0);
    op("R7 di", 0, 0, 8'h8B, 1, 1, 0, 5'd7, 3'd3, 0, 0);
  endtask

  task automatic t_acd();
    op("R8 ax 16", 0, 0, 8'h8B, 1, 0, 0, 5'd0, 3'd7, 1, 0);
    op("R8 dx 16", 0, 0, 8'h8B, 1, 0, 0, 5'd2, 3'd7, 1, 0);
    op("R8 cx 32", 0, 0, 8'h8B, 1, 1, 0, 5'd1, 3'd3, 0, 0);
    op("R8 dx 64", 0, 0, 8'h8B, 1, 2, 0, 5'd2, 3'd3, 0, 0);
    op("R8 ax 16 ovr", 32'h26, 1, 8'h8B, 1, 0, 0, 5'd0, 3'd0, 0, 0);
  endtask

  task automatic t_long();
    op("R9 default", 0, 0, 8'h8B, 1, 2, 1, 5'd3, 3'd6, 0, 0);
    op("R9 fs", 32'h64, 1, 8'h8B, 1, 2, 1, 5'd3, 3'd4, 0, 0);
    op("R9 gs", 32'h65, 1, 8'h8B, 1, 2, 1, 5'd5, 3'd5, 0, 0);
    op("R9 cs dropped", 32'h2E, 1, 8'h8B, 1, 2, 1, 5'd3, 3'd6, 0, 0);
    op("R9 es dropped", 32'h26, 1, 8'h8B, 1, 2, 1, 5'd4, 3'd6, 0, 0);
    op("R9 ax 16", 0, 0, 8'h8B, 1, 0, 1, 5'd0, 3'd6, 0, 0);
  endtask

  task automatic t_odd();
    op("R10 r9 legacy", 0, 0, 8'h8B, 1, 1, 0, 5'd9, 3'd3, 0, 1);
    op("R10 r9 long", 0, 0, 8'h8B, 1, 2, 1, 5'd9, 3'd6, 0, 0);
    op("R10 code20", 0, 0, 8'h8B, 1, 1, 0, 5'd20, 3'd3, 0, 1);
    op("R10 code20 fs", 32'h64, 1, 8'h8B, 1, 1, 0, 5'd20, 3'd4, 0, 1);
    op("R10 bx clear", 0, 0, 8'h8B, 1, 1, 0, 5'd3, 3'd3, 0, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_latency();
    t_string();
    t_override();
    t_multi();
    t_ip();
    t_di_string();
    t_defaults();
    t_acd();
    t_long();
    t_odd();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule